// File: doc/BRIEF.md
# Parcel-Granular Instruction Aligner

This block sits between an instruction fetch buffer and the decoder. Fetch data arrives as fixed-width chunks of little-endian bytes under a valid/ready handshake. The block packs these chunks into a byte queue. Instruction boundaries fall on 3-byte parcels.

The block reads the length code in the two lowest bits of the instruction at the head of the queue. An instruction is one, two or four parcels long. When every byte of that instruction is present, the block hands the whole instruction to the decoder in a single cycle. The output carries a length tag and the instruction's start byte address. The reserved length code is flagged as illegal and consumes one parcel.

Bytes left over after an instruction are kept for the next chunk. A redirect empties the queue and loads a new start address.

Top module: `vl_parcel_aligner`

## Requirements
- R1: After reset, `insn_valid_o` is 0 and `fetch_ready_o` is 1.
- R2: `insn_len_o` equals bits [1:0] of the head byte. Code 2'b00 emits 3 bytes, 2'b01 emits 6 bytes and 2'b10 emits 12 bytes.
- R3: Head code 2'b11 is reserved. The block emits one 3-byte parcel with `insn_illegal_o`=1. For every other code, `insn_illegal_o` is 0.
- R4: Byte i of an instruction, counted from its start, appears on `insn_o[8i+7:8i]`. All bits above the instruction's length are 0.
- R5: `insn_addr_o` is the start byte address of the instruction being presented. After each instruction is taken, the address advances by 3, 6 or 12, matching the bytes consumed.
- R6: `insn_valid_o` stays 0 until every byte of the head instruction is buffered. A partial instruction is held, and `fetch_ready_o` stays 1 while there is room for another chunk.
- R7: `fetch_ready_o` is 1 exactly when the queue has room for one full chunk. With the defaults (6-byte chunks, 24-byte queue), four chunks are accepted before ready drops. Bytes are kept in order across chunk boundaries.
- R8: A cycle with `redirect_i`=1 clears all buffered bytes and loads `redirect_addr_i`. In that cycle there is no output, and any fetch chunk offered is dropped. Only data fetched afterwards is emitted, starting at the new address.
- R9: While `insn_valid_o`=1 and `insn_ready_i`=0, with no redirect, the output instruction and address are held stable into the next cycle.
- R10: A redirect address minus `CODE_BASE` is a multiple of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| redirect_i | input | 1 | Flush queue and load a new start address |
| redirect_addr_i | input | ADDR_W | New start byte address |
| fetch_valid_i | input | 1 | Fetch chunk valid |
| fetch_data_i | input | 8*FETCH_BYTES | Fetch chunk; lowest byte is earliest |
| fetch_ready_o | output | 1 | Queue has room for one chunk |
| insn_valid_o | output | 1 | Whole instruction present |
| insn_ready_i | input | 1 | Decoder takes the instruction |
| insn_o | output | 96 | Instruction bytes from bit 0, zero above |
| insn_len_o | output | 2 | Length code of the instruction |
| insn_illegal_o | output | 1 | Reserved length code seen |
| insn_addr_o | output | ADDR_W | Start byte address of the instruction |

## Verification
The main sweep streams every ordered triple of the four length codes back to back, so each pair of neighbouring lengths appears at every byte offset within a 6-byte chunk. This separates a correct carry of leftover bytes from a mistake in the split or the shift, and separates the illegal one-parcel step from a guessed longer one.

The decoder stalls in a fixed pattern during the sweep, which shows whether a held output stays stable or is lost. A lone 12-byte instruction split over two chunks shows whether the block waits for its tail or emits early. A half instruction followed by a redirect, with junk offered in the redirect cycle, shows whether stale or dropped bytes leak into the new stream. Filling the queue while the decoder is stopped checks the exact point at which fetch ready drops.

// File: rtl/vl_align_pkg.sv
package vl_align_pkg;
  localparam int PARCEL_BYTES = 3;
  localparam int MAX_BYTES    = 12;
  localparam int INSN_W       = 8 * MAX_BYTES;

  typedef enum logic [1:0] {
    LEN_P1  = 2'b00,
    LEN_P2  = 2'b01,
    LEN_P4  = 2'b10,
    LEN_RSV = 2'b11
  } len_code_e;

  function automatic logic [3:0] code_bytes(input logic [1:0] code);
    case (code)
      LEN_P2:  return 4'd6;
      LEN_P4:  return 4'd12;
      default: return 4'd3;   // one parcel, also for the reserved code
    endcase
  endfunction
endpackage

// File: rtl/vl_byte_queue.sv
module vl_byte_queue #(
  parameter int BUF_BYTES   = 24,
  parameter int FETCH_BYTES = 6,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     push_i,
  input  logic [8*FETCH_BYTES-1:0] push_data_i,
  input  logic                     pop_i,
  input  logic [3:0]               pop_bytes_i,
  output logic [vl_align_pkg::INSN_W-1:0] head_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     space_o
);
  import vl_align_pkg::*;

  logic [7:0]       mem_q [BUF_BYTES];
  logic [7:0]       mem_d [BUF_BYTES];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign space_o = int'(cnt_q) <= BUF_BYTES - FETCH_BYTES;
  assign cnt_o   = cnt_q;

  generate
    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_head
      assign head_o[8*j +: 8] = mem_q[j];
    end
  endgenerate

  always_comb begin
    int pop_n;
    int keep_n;
    pop_n  = pop_i ? int'(pop_bytes_i) : 0;
    keep_n = int'(cnt_q) - pop_n;
    for (int i = 0; i < BUF_BYTES; i++) begin
      mem_d[i] = 8'h00;
      if (i < keep_n) begin
        if (i + pop_n < BUF_BYTES) mem_d[i] = mem_q[i + pop_n];
      end else if (push_i && (i < keep_n + FETCH_BYTES)) begin
        mem_d[i] = push_data_i[8*(i - keep_n) +: 8];
      end
    end
    if (flush_i) cnt_d = '0;
    else cnt_d = CNT_W'(keep_n + (push_i ? FETCH_BYTES : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= mem_d[i];
  end

  p_pop_avail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (int'(pop_bytes_i) <= int'(cnt_q)));
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (int'(cnt_q) + FETCH_BYTES <= BUF_BYTES));
endmodule

// File: rtl/vl_len_decode.sv
module vl_len_decode #(
  parameter int CNT_W = 5
) (
  input  logic [1:0]       code_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [3:0]       need_o,
  output logic             complete_o,
  output logic             illegal_o
);
  import vl_align_pkg::*;

  assign need_o     = code_bytes(code_i);
  assign complete_o = int'(cnt_i) >= int'(need_o);
  assign illegal_o  = (code_i == LEN_RSV);
endmodule

// File: rtl/vl_insn_pack.sv
module vl_insn_pack (
  input  logic [vl_align_pkg::INSN_W-1:0] head_i,
  input  logic [1:0]                      code_i,
  output logic [vl_align_pkg::INSN_W-1:0] insn_o
);
  import vl_align_pkg::*;

  localparam int NPAR = MAX_BYTES / PARCEL_BYTES;
  localparam int PW   = 8 * PARCEL_BYTES;

  logic [2:0] npar;
  always_comb begin
    case (code_i)
      LEN_P2:  npar = 3'd2;
      LEN_P4:  npar = 3'd4;
      default: npar = 3'd1;
    endcase
  end

  generate
    for (genvar p = 0; p < NPAR; p++) begin : g_par
      assign insn_o[PW*p +: PW] = (p < int'(npar)) ? head_i[PW*p +: PW] : '0;
    end
  endgenerate
endmodule

// File: rtl/vl_parcel_aligner.sv
module vl_parcel_aligner #(
  parameter int FETCH_BYTES          = 6,
  parameter int BUF_BYTES            = 24,
  parameter int ADDR_W               = 32,
  parameter logic [31:0] CODE_BASE   = 32'h0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     redirect_i,
  input  logic [ADDR_W-1:0]        redirect_addr_i,
  input  logic                     fetch_valid_i,
  input  logic [8*FETCH_BYTES-1:0] fetch_data_i,
  output logic                     fetch_ready_o,
  output logic                     insn_valid_o,
  input  logic                     insn_ready_i,
  output logic [95:0]              insn_o,
  output logic [1:0]               insn_len_o,
  output logic                     insn_illegal_o,
  output logic [ADDR_W-1:0]        insn_addr_o
);
  import vl_align_pkg::*;

  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [INSN_W-1:0] head;
  logic [CNT_W-1:0]  cnt;
  logic              space, push, pop, complete, illegal;
  logic [3:0]        need;
  logic [1:0]        code;
  logic [ADDR_W-1:0] pc_q;

  assign code          = head[1:0];
  assign push          = fetch_valid_i && space && !redirect_i;
  assign insn_valid_o  = complete && !redirect_i;
  assign pop           = insn_valid_o && insn_ready_i;
  assign fetch_ready_o = space;
  assign insn_len_o    = code;
  assign insn_illegal_o = illegal;
  assign insn_addr_o   = pc_q;

  vl_byte_queue #(.BUF_BYTES(BUF_BYTES), .FETCH_BYTES(FETCH_BYTES)) i_queue (
    .clk_i, .rst_ni,
    .flush_i(redirect_i), .push_i(push), .push_data_i(fetch_data_i),
    .pop_i(pop), .pop_bytes_i(need),
    .head_o(head), .cnt_o(cnt), .space_o(space)
  );

  vl_len_decode #(.CNT_W(CNT_W)) i_len (
    .code_i(code), .cnt_i(cnt), .need_o(need),
    .complete_o(complete), .illegal_o(illegal)
  );

  vl_insn_pack i_pack (.head_i(head), .code_i(code), .insn_o(insn_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= ADDR_W'(CODE_BASE);
    else if (redirect_i) pc_q <= redirect_addr_i;
    else if (pop)        pc_q <= pc_q + ADDR_W'(need);
  end

  initial begin
    assert (BUF_BYTES >= MAX_BYTES + FETCH_BYTES)
      else $error("queue too small for a full instruction plus a chunk");
  end

  p_pc_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_o && insn_ready_i) |=>
      (insn_addr_o == $past(insn_addr_o) + ADDR_W'($past(insn_len_o == 2'b10 ? 4'd12 :
                                                          insn_len_o == 2'b01 ? 4'd6 : 4'd3))));
  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (!insn_valid_o && fetch_ready_o && insn_addr_o == $past(redirect_addr_i)));
  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_o && !insn_ready_i) |=>
      (redirect_i || (insn_valid_o && $stable(insn_o) && $stable(insn_addr_o))));
  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_o && insn_len_o != 2'b10) |-> (insn_o[95:48] == '0));
  p_illegal_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_o && insn_illegal_o) |-> (insn_o[95:24] == '0));
  p_redir_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> ((redirect_addr_i - ADDR_W'(CODE_BASE)) % 3 == 0));
endmodule

// File: tb/test_vl_parcel_aligner.sv
module test_vl_parcel_aligner;
  localparam int FB = 6;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_addr_i = '0;
  logic          fetch_valid_i = 1'b0;
  logic [8*FB-1:0] fetch_data_i = '0;
  logic          fetch_ready_o;
  logic          insn_valid_o;
  logic          insn_ready_i = 1'b1;
  logic [95:0]   insn_o;
  logic [1:0]    insn_len_o;
  logic          insn_illegal_o;
  logic [AW-1:0] insn_addr_o;

  always #10 clk_i = ~clk_i;   // 50 MHz

  vl_parcel_aligner #(.FETCH_BYTES(FB), .BUF_BYTES(24), .ADDR_W(AW), .CODE_BASE(32'h0))
  i_vl_parcel_aligner (
    .clk_i, .rst_ni, .redirect_i, .redirect_addr_i, .fetch_valid_i, .fetch_data_i,
    .fetch_ready_o, .insn_valid_o, .insn_ready_i, .insn_o, .insn_len_o,
    .insn_illegal_o, .insn_addr_o
  );

  int n_tests = 0, n_fail = 0;
  int exp_wr = 0, exp_rd = 0;
  logic [95:0]   e_insn [512];
  logic [1:0]    e_len  [512];
  logic [AW-1:0] e_addr [512];
  logic [7:0]    prog [4096];
  int pw = 0, pr = 0;
  logic [AW-1:0] cur_addr = '0;
  bit stall_en = 0, stall_all = 0, mon_on = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b01) ? 6 : (c == 2'b10) ? 12 : 3;
  endfunction

  // append one instruction to the byte store and the expectation list
  task automatic add_insn(input logic [1:0] c);
    logic [95:0] v = '0;
    for (int j = 0; j < nbytes(c); j++) begin
      logic [7:0] b = 8'((exp_wr * 29 + j * 11 + 7) & 255);
      if (j == 0) b = {b[7:2], c};
      v[8*j +: 8] = b;
      prog[pw] = b;
      pw++;
    end
    e_insn[exp_wr] = v;
    e_len[exp_wr]  = c;
    e_addr[exp_wr] = cur_addr;
    cur_addr = cur_addr + AW'(nbytes(c));
    exp_wr++;
  endtask

  task automatic send_chunk(input logic [8*FB-1:0] d);
    @(negedge clk_i);
    fetch_valid_i = 1'b1;
    fetch_data_i  = d;
    #1;
    while (!fetch_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i); #1;
    fetch_valid_i = 1'b0;
  endtask

  task automatic feed_prog();
    while (pr + FB <= pw) begin
      logic [8*FB-1:0] d;
      for (int k = 0; k < FB; k++) d[8*k +: 8] = prog[pr + k];
      pr += FB;
      send_chunk(d);
    end
  endtask

  // R8: junk offered in the redirect cycle must be dropped; R10: targets are multiples of 3
  task automatic do_redirect(input logic [AW-1:0] a);
    @(negedge clk_i);
    redirect_i = 1'b1;
    redirect_addr_i = a;
    fetch_valid_i = 1'b1;
    fetch_data_i = 48'hA5A5_A5A5_A502;
    @(posedge clk_i); #1;
    redirect_i = 1'b0;
    fetch_valid_i = 1'b0;
    cur_addr = a;
    pr = pw;
  endtask

  task automatic drain();
    for (int t = 0; t < 4000 && exp_rd != exp_wr; t++) @(negedge clk_i);
  endtask

  // output monitor: sample away from the rising edge
  always @(negedge clk_i) begin
    bit rdy;
    cyc++;
    rdy = !stall_all && !(stall_en && (cyc % 5 == 2));
    insn_ready_i = rdy;
    if (mon_on && insn_valid_o && rdy) begin
      if (exp_rd >= exp_wr) begin
        chk(0, "R8 unexpected output", insn_o, '0);
      end else begin
        chk(insn_o == e_insn[exp_rd], "R4 insn bytes", insn_o, e_insn[exp_rd]);
        chk(insn_len_o == e_len[exp_rd], "R2 length tag", 96'(insn_len_o), 96'(e_len[exp_rd]));
        chk(insn_illegal_o == (e_len[exp_rd] == 2'b11), "R3 illegal flag",
            96'(insn_illegal_o), 96'(e_len[exp_rd] == 2'b11));
        chk(insn_addr_o == e_addr[exp_rd], "R5 start address", 96'(insn_addr_o), 96'(e_addr[exp_rd]));
        exp_rd++;
      end
    end
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk_i);
    chk(0, "watchdog expired", '0, '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(insn_valid_o == 1'b0, "R1 valid after reset", 96'(insn_valid_o), 96'd0);
    chk(fetch_ready_o == 1'b1, "R1 ready after reset", 96'(fetch_ready_o), 96'd1);
    mon_on = 1;

    // R6: 12-byte instruction split over two chunks
    do_redirect(32'h30);
    add_insn(2'b10);
    begin
      logic [8*FB-1:0] d;
      for (int k = 0; k < FB; k++) d[8*k +: 8] = prog[pr + k];
      pr += FB;
      send_chunk(d);
    end
    repeat (4) @(negedge clk_i);
    #1;
    chk(insn_valid_o == 1'b0, "R6 partial held", 96'(insn_valid_o), 96'd0);
    chk(fetch_ready_o == 1'b1, "R6 ready while partial", 96'(fetch_ready_o), 96'd1);
    feed_prog();
    drain();
    chk(exp_rd == exp_wr, "R6 emitted once complete", 96'(exp_rd), 96'(exp_wr));

    // R8: stale half instruction then redirect
    send_chunk(48'h1111_2222_3302);
    do_redirect(32'h60);
    add_insn(2'b00);
    add_insn(2'b00);
    feed_prog();
    drain();
    chk(exp_rd == exp_wr, "R8 new stream only", 96'(exp_rd), 96'(exp_wr));

    // R7 / R9: fill the queue with the decoder stopped
    stall_all = 1;
    do_redirect(32'h90);
    for (int i = 0; i < 8; i++) add_insn(2'b00);
    feed_prog();
    @(negedge clk_i); #1;
    chk(fetch_ready_o == 1'b0, "R7 ready low when full", 96'(fetch_ready_o), 96'd0);
    begin
      logic [95:0] h0;
      h0 = insn_o;
      @(negedge clk_i); #1;
      chk(insn_valid_o && insn_o == h0, "R9 held under stall", insn_o, h0);
      chk(insn_o == e_insn[exp_rd], "R9 held value", insn_o, e_insn[exp_rd]);
    end
    stall_all = 0;
    drain();
    chk(exp_rd == exp_wr, "R7 full queue drained in order", 96'(exp_rd), 96'(exp_wr));

    // R2 R3 R5 R7 R9: every ordered triple of codes, periodic decoder stall
    stall_en = 1;
    do_redirect(32'h300);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          add_insn(2'(a));
          add_insn(2'(b));
          add_insn(2'(c));
        end
    if ((pw - pr) % FB != 0) add_insn(2'b00);
    feed_prog();
    drain();
    chk(exp_rd == exp_wr, "R2 sweep all emitted", 96'(exp_rd), 96'(exp_wr));
    stall_en = 0;

    repeat (3) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule